// File: doc/BRIEF.md
# Write-Locked Register Access Port over SPI

This block is a register access port for a serial configuration link. An SPI slave in mode 0 receives one 32-bit command per chip-select frame. A set top bit marks a write and a clear top bit marks a read. A 7-bit register address and a 16-bit data field complete the command. In the frame that follows, the block shifts out a 32-bit response that holds the register addressed by the previous accepted command. The upper half of the response is always zero.

A small key register sits at address zero. Writes to every other register take effect only after the two key words have been written to it in order. Reads are never restricted. The registers behind the port are simple storage:

- a dwell-time setting,
- four interface control flags,
- a read-only mirror of an input status bus,
- a read-only revision constant.

The serial pins are brought into the system clock domain through two-flop synchronisers. A frame that did not carry exactly 32 clock pulses is thrown away.

Top module: `csr_spi_gate`

## Requirements
- R1: A command word is decoded as follows: bit 31 = 1 means write and bit 31 = 0 means read, bits 30..24 are the register address, bits 15..0 are the write data, and bits 23..16 have no effect.
- R2: During the frame that follows an accepted command, the response shifted out on `spi_miso` (MSB first, mode 0) is {16'h0000, V}. V is the addressed register's readable value, taken when chip select falls for that next frame, so it includes the command's own write.
- R3: Reading address 0x00 returns the key state: 0x0000 when locked, 0x0001 after the first key word, 0x0003 when unlocked.
- R4: Writing 0xA569 to address 0x00 always sets the key state to 0x0001, from any state including 0x0003.
- R5: Writing 0x1248 to address 0x00 while the state is 0x0001 sets 0x0003. Writing any other value to 0x00, including 0x1248 from another state, sets 0x0000.
- R6: A write to any address other than 0x00 changes nothing unless the key state is 0x0003. Reads return the same data whatever the key state.
- R7: Address 0x01 holds a 10-bit dwell time taken from data bits 9..0. It reads back zero-extended and drives `dwell_q`.
- R8: Address 0x02 stores only data bits 15..12 and drives `ctrl_q` (bit 3 of `ctrl_q` = data bit 15). A read of 0x02 returns those flags in bits 15..12 and zero elsewhere.
- R9: Address 0x03 reads the live `status_in` bus, and 0x7F reads the revision constant (default 0x0107). Both ignore writes. Other addresses read 0 and ignore writes.
- R10: A frame with fewer or more than 32 SCK rising edges while chip select is low is discarded. It causes no write and does not change which register the next response reports.
- R11: After reset the block is locked, `dwell_q` and `ctrl_q` are 0, `spi_miso` is 0, and the first response reports address 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, idle low (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select that frames each word |
| spi_mosi | input | 1 | Serial command data, MSB first |
| spi_miso | output | 1 | Serial response data, MSB first |
| status_in | input | 16 | Live status bus mirrored at address 0x03 |
| dwell_q | output | 10 | Stored dwell-time setting |
| ctrl_q | output | 4 | Stored interface control flags |

## Verification
Some behaviours are checked by assertions on every cycle:
- the key state transitions for the first key word, the second key word and any cancelling value;
- the key state holding when no key write arrives;
- the dwell and control registers staying still under a write while locked;
- the response shifter moving only on a frame start or an SCK falling edge, with a zero upper half after each load.

Other behaviours only the bench scenarios can show:
- the full serial round trip, where a response lands in the frame after its command;
- the discarding of short and long frames;
- the live status mirror;
- the revision and unmapped read values;
- the re-entry and cancel orderings of the key sequence as seen from the pins.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;
  localparam int CMD_W  = 32;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_KEY   = 7'h00;
  localparam logic [ADDR_W-1:0] A_DWELL = 7'h01;
  localparam logic [ADDR_W-1:0] A_CTRL  = 7'h02;
  localparam logic [ADDR_W-1:0] A_STAT  = 7'h03;
  localparam logic [ADDR_W-1:0] A_REV   = 7'h7F;

  // encodings are the values read back from the key register
  typedef enum logic [1:0] {
    KEY_SHUT = 2'b00,
    KEY_HALF = 2'b01,
    KEY_OPEN = 2'b11
  } key_e;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  // R1: field extraction, bits 23..16 are dropped
  function automatic cmd_t split_cmd(input logic [CMD_W-1:0] w);
    cmd_t c;
    c.wr   = w[CMD_W-1];
    c.addr = w[CMD_W-2 -: ADDR_W];
    c.data = w[DATA_W-1:0];
    return c;
  endfunction

  // R4/R5: next key state on a write to the key register
  function automatic key_e key_step(input key_e cur, input logic [DATA_W-1:0] d,
                                    input logic [DATA_W-1:0] k1, input logic [DATA_W-1:0] k2);
    if (d == k1)                          return KEY_HALF;
    else if (d == k2 && cur == KEY_HALF)  return KEY_OPEN;
    else                                  return KEY_SHUT;
  endfunction

  function automatic logic [DATA_W-1:0] key_view(input key_e s);
    return {{(DATA_W-2){1'b0}}, s};
  endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_word_port.sv
module spi_word_port #(
  parameter int FRAME_BITS  = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RESP_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck,
  input  logic                  cs_n,
  input  logic                  mosi,
  output logic                  miso,
  input  logic [RESP_W-1:0]     resp_data,
  output logic                  word_valid,
  output logic [FRAME_BITS-1:0] word
);
  localparam int CNT_MAX = FRAME_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic sck_s, cs_s, mosi_s;
  logic sck_d, cs_d;

  bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck  (.clk(clk), .rst_n(rst_n), .d(sck),  .q(sck_s));
  bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs   (.clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
  bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mosi (.clk(clk), .rst_n(rst_n), .d(mosi), .q(mosi_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  // named events for the assertions
  logic in_frame, sck_rise, sck_fall, frame_start, frame_end;
  assign in_frame    = ~cs_s;
  assign sck_rise    = in_frame & sck_s & ~sck_d;
  assign sck_fall    = in_frame & ~sck_s & sck_d;
  assign frame_start = ~cs_s & cs_d;
  assign frame_end   = cs_s & ~cs_d;

  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] rx_sr, tx_sr;
  logic                  len_ok;

  assign len_ok = (bit_cnt == CNT_W'(FRAME_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= frame_end & len_ok;
      if (frame_start) begin
        bit_cnt <= '0;
        rx_sr   <= '0;
        tx_sr   <= {{(FRAME_BITS-RESP_W){1'b0}}, resp_data};
      end else begin
        if (sck_rise) begin
          rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_s};
          if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sck_fall) tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  assign word = rx_sr;
  assign miso = tx_sr[FRAME_BITS-1];

  // R2: shifter moves only at frame start or an SCK falling edge
  a_r2_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !sck_fall) |=> $stable(tx_sr));
  // R2: freshly loaded response has a zero upper half
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (tx_sr[FRAME_BITS-1:RESP_W] == '0));
  // R10: a word is only delivered once chip select is released
  a_r10_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> cs_s);
endmodule

// File: rtl/csr_key_seq.sv
module csr_key_seq
  import csr_gate_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_FIRST  = 16'hA569,
  parameter logic [DATA_W-1:0] KEY_SECOND = 16'h1248
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output key_e              key_state,
  output logic              wr_open
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_state <= KEY_SHUT;
    else if (key_wr) key_state <= key_step(key_state, key_data, KEY_FIRST, KEY_SECOND);
  end

  assign wr_open = (key_state == KEY_OPEN);

  a_r4_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data == KEY_FIRST) |=> key_state == KEY_HALF);
  a_r5_second_word: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data == KEY_SECOND && key_state == KEY_HALF) |=> key_state == KEY_OPEN);
  a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data != KEY_FIRST && !(key_data == KEY_SECOND && key_state == KEY_HALF))
      |=> key_state == KEY_SHUT);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(key_state));
endmodule

// File: rtl/csr_store.sv
module csr_store
  import csr_gate_pkg::*;
#(
  parameter int                DWELL_W  = 10,
  parameter int                CTRL_LSB = 12,
  parameter int                CTRL_W   = 4,
  parameter logic [DATA_W-1:0] REVISION = 16'h0107
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  cmd_t              cmd,
  input  logic              wr_open,
  input  key_e              key_state,
  input  logic [DATA_W-1:0] status_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DWELL_W-1:0] dwell_q,
  output logic [CTRL_W-1:0]  ctrl_q
);
  logic wr_go;
  assign wr_go = cmd_valid & cmd.wr & wr_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell_q <= '0;
      ctrl_q  <= '0;
    end else if (wr_go) begin
      if (cmd.addr == A_DWELL) dwell_q <= cmd.data[DWELL_W-1:0];
      if (cmd.addr == A_CTRL)  ctrl_q  <= cmd.data[CTRL_LSB +: CTRL_W];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_KEY:   rd_data = key_view(key_state);
      A_DWELL: rd_data[DWELL_W-1:0] = dwell_q;
      A_CTRL:  rd_data[CTRL_LSB +: CTRL_W] = ctrl_q;
      A_STAT:  rd_data = status_in;
      A_REV:   rd_data = REVISION;
      default: rd_data = '0;
    endcase
  end

  // R6: a write while not unlocked leaves storage untouched
  a_r6_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd.wr && !wr_open) |=> ($stable(dwell_q) && $stable(ctrl_q)));
  // R9: writes to other addresses never move storage
  a_r9_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd.addr != A_DWELL && cmd.addr != A_CTRL) |=> ($stable(dwell_q) && $stable(ctrl_q)));
endmodule

// File: rtl/csr_spi_gate.sv
module csr_spi_gate
  import csr_gate_pkg::*;
#(
  parameter int                FRAME_BITS  = 32,
  parameter int                SYNC_STAGES = 2,
  parameter int                DWELL_W     = 10,
  parameter int                CTRL_W      = 4,
  parameter logic [15:0]       REVISION    = 16'h0107,
  parameter logic [15:0]       KEY_FIRST   = 16'hA569,
  parameter logic [15:0]       KEY_SECOND  = 16'h1248
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sck,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso,
  input  logic [15:0]        status_in,
  output logic [DWELL_W-1:0] dwell_q,
  output logic [CTRL_W-1:0]  ctrl_q
);
  localparam int CTRL_LSB = DATA_W - CTRL_W;

  logic                  word_valid;
  logic [FRAME_BITS-1:0] word;
  logic [DATA_W-1:0]     rd_data;
  logic [ADDR_W-1:0]     last_addr;
  cmd_t                  cmd;
  key_e                  key_state;
  logic                  wr_open, key_wr;

  spi_word_port #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES), .RESP_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .miso(spi_miso), .resp_data(rd_data), .word_valid(word_valid), .word(word));

  assign cmd    = split_cmd(word[CMD_W-1:0]);
  assign key_wr = word_valid & cmd.wr & (cmd.addr == A_KEY);

  csr_key_seq #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(cmd.data),
    .key_state(key_state), .wr_open(wr_open));

  csr_store #(.DWELL_W(DWELL_W), .CTRL_LSB(CTRL_LSB), .CTRL_W(CTRL_W), .REVISION(REVISION)) u_store (
    .clk(clk), .rst_n(rst_n), .cmd_valid(word_valid), .cmd(cmd), .wr_open(wr_open),
    .key_state(key_state), .status_in(status_in), .rd_addr(last_addr), .rd_data(rd_data),
    .dwell_q(dwell_q), .ctrl_q(ctrl_q));

  // address reported by the next response frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          last_addr <= A_KEY;
    else if (word_valid) last_addr <= cmd.addr;
  end

  // R2: the response follows the most recently accepted command
  a_r2_addr_track: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> last_addr == $past(cmd.addr));
  // R10: without an accepted word the reported address holds
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> $stable(last_addr));
endmodule

// File: tb/csr_spi_gate_tb.sv
module csr_spi_gate_tb;
  localparam int HALF = 8;
  localparam int GAP  = 12;
  localparam int NV   = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [15:0] status = 16'h5A3C;
  logic [9:0]  dwell;
  logic [3:0]  ctrl;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  csr_spi_gate u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .status_in(status), .dwell_q(dwell), .ctrl_q(ctrl));

  // command, and response expected in the same frame (result of previous command)
  localparam logic [31:0] V_CMD [NV] = '{
    32'h0000_0000, // 0  read key            R11 reset response
    32'h8100_0155, // 1  write dwell locked  R3
    32'h0100_0000, // 2  read dwell          R6 blocked write
    32'h8000_A569, // 3  first key           R6
    32'h0000_0000, // 4  read key            R4
    32'h8000_1248, // 5  second key          R3
    32'h81AB_FF55, // 6  write dwell, junk 23..16  R5
    32'h8200_FFFF, // 7  write ctrl          R1 R7
    32'h0300_0000, // 8  read status         R8
    32'h7F00_0000, // 9  read revision       R9
    32'h0500_0000, // 10 read unmapped       R9
    32'h8300_1111, // 11 write status        R9
    32'h8000_A569, // 12 first key from open R9
    32'h00FF_0000, // 13 read key junk bits  R4
    32'h8000_1248, // 14 second key          R1
    32'h8000_1248, // 15 second key again    R5
    32'h0000_0000, // 16 read key            R5
    32'h8200_0000, // 17 write ctrl locked   R3
    32'h0200_0000, // 18 read ctrl           R6
    32'h8000_1248, // 19 second key alone    R6
    32'h0000_0000, // 20 read key            R5
    32'h8000_A569, // 21 first key           R5
    32'h8000_0001, // 22 wrong value         R4
    32'h0000_0000  // 23 read key            R5
  };
  localparam logic [15:0] V_EXP [NV] = '{
    16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h0001,
    16'h0003, 16'h0355, 16'hF000, 16'h5A3C, 16'h0107, 16'h0000,
    16'h5A3C, 16'h0001, 16'h0001, 16'h0003, 16'h0000, 16'h0000,
    16'hF000, 16'hF000, 16'h0000, 16'h0000, 16'h0001, 16'h0000
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int nbits, input logic [31:0] cmd, output logic [31:0] resp);
    resp = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      mosi = (b < 32) ? cmd[31-b] : 1'b0;
      repeat (HALF) @(negedge clk);
      resp = {resp[30:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state at the ports
    check("R11 dwell after reset", 32'(dwell), 32'h0);
    check("R11 ctrl after reset", 32'(ctrl), 32'h0);
    check("R11 miso after reset", 32'(miso), 32'h0);

    // vector walk: R1..R9 via the serial round trip (R2)
    for (int i = 0; i < NV; i++) begin
      xfer(32, V_CMD[i], r);
      check($sformatf("R2 vector %0d response", i), r, {16'h0000, V_EXP[i]});
    end
    check("R7 dwell port", 32'(dwell), 32'h355);
    check("R8 ctrl port", 32'(ctrl), 32'hF);

    // R9 live status mirror
    status = 16'hC3A5;
    xfer(32, 32'h0300_0000, r);
    xfer(32, 32'h0000_0000, r);
    check("R9 live status", r, 32'h0000_C3A5);

    // R5 full unlock from locked
    xfer(32, 32'h8000_A569, r);
    xfer(32, 32'h8000_1248, r);
    xfer(32, 32'h0000_0000, r);
    check("R5 unlocked state", r, 32'h0000_0003);

    // R10 short and long frames are discarded
    xfer(31, 32'h8100_0000, r);
    check("R10 short frame no write", 32'(dwell), 32'h355);
    xfer(33, 32'h8100_0000, r);
    check("R10 long frame no write", 32'(dwell), 32'h355);
    xfer(32, 32'h0200_0000, r);
    check("R10 response unchanged", r, 32'h0000_0003);

    // R7 allowed write to dwell
    xfer(32, 32'h8100_0000, r);
    check("R7 dwell cleared", 32'(dwell), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule